// File: doc/BRIEF.md
# Segment Base-Limit Translator

This block turns a logical address into a physical address for a memory system that is organised in variable-length segments. A request carries a segment number, an offset within that segment and an access kind. The block first checks the segment number against the number of valid table rows, which is held in a length input. It then searches a small fully associative cache keyed by segment number. On a miss it fetches the descriptor through a single-outstanding read port. The read address is the table origin input plus the segment number.

A descriptor holds a base address, a segment length and three permission bits. The offset must be strictly below the length, and the access kind must be allowed by the permissions. When both hold, the physical address is the arithmetic sum of base and offset. When they do not, exactly one fault flag is raised, chosen by a fixed priority.

Any change of the origin or length input empties the cache, so translations never use descriptors from a previous table. Requests use a valid/ready handshake and are served one at a time. Each accepted request produces exactly one single-cycle response.

Top module: `seg_xlate`

## Requirements
- R1: A translation that raises no fault returns the physical address base + offset, computed as an arithmetic sum truncated to the physical address width.
- R2: A segment number greater than or equal to `tbl_len` raises the segment fault, and no table read is issued for that request.
- R3: An offset greater than or equal to the descriptor length raises the bounds fault. A descriptor with length zero therefore faults on every offset, and an offset of length-1 is in bounds.
- R4: The access code on `req_acc` is 0 for read, 1 for write, 2 for execute and 3 for reserved. The permission bits of the descriptor are bit 0 for read, bit 1 for write and bit 2 for execute. A request whose code has no matching set bit raises the protection fault, and code 3 always raises it.
- R5: At most one fault flag is set in a response. The priority is segment fault, then bounds fault, then protection fault. `rsp_paddr` is zero whenever a fault is set.
- R6: On a cache miss, exactly one single-cycle read is issued at `tbl_origin + segment`. The returned word holds the base in bits [19:0], the length in bits [32:20] and the permissions in bits [35:33].
- R7: A request whose segment is held in the cache issues no table read. Every miss fills one of `TC_DEPTH` slots, and the slots are replaced in round-robin order starting from slot 0.
- R8: A change in the value of `tbl_origin` or `tbl_len` empties the cache and sets the replacement order back to slot 0.
- R9: `req_ready` is high only while no request is in progress. Every accepted request yields exactly one response, and `rsp_valid` is high for one cycle.
- R10: After reset, `req_ready` is high and `rsp_valid` and `mem_rd_en` are low, and the cache is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tbl_origin | input | 16 | Memory address of descriptor 0 |
| tbl_len | input | 7 | Number of valid descriptors |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_seg | input | 6 | Segment number |
| req_off | input | 12 | Offset within the segment |
| req_acc | input | 2 | Access code (0 read, 1 write, 2 execute, 3 reserved) |
| mem_rd_en | output | 1 | Descriptor read strobe |
| mem_addr | output | 16 | Descriptor read address |
| mem_rd_valid | input | 1 | Descriptor data valid |
| mem_rd_data | input | 36 | Descriptor word |
| rsp_valid | output | 1 | Response present, one cycle |
| rsp_paddr | output | 20 | Physical address, zero on fault |
| rsp_fault_seg | output | 1 | Segment number out of range |
| rsp_fault_bound | output | 1 | Offset not below segment length |
| rsp_fault_prot | output | 1 | Access kind not permitted |

## Verification
The bench targets five kinds of edge cases:
- **Length boundaries.** It probes offsets of length-1 and exactly the length, and a zero-length descriptor. An off-by-one compare would accept the last illegal offset or reject the last legal one.
- **Segment-number edge.** It sends the first segment number equal to the table length. A design using a strict greater-than compare would fetch a nonexistent descriptor.
- **Fault priority.** It combines faults in one request, so a wrong priority order or a non-exclusive encoding shows up as the wrong flag, or as several flags at once.
- **Cache behaviour.** It counts table reads per request. An extra read exposes a cache that never hits, and a missing read after eviction exposes a wrong replacement order.
- **Stale descriptors.** It changes the origin and the length while the cache is warm. A block without the flush would return the stale base address.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

    parameter int SEG_W  = 6;
    parameter int OFF_W  = 12;
    parameter int PA_W   = 20;
    parameter int MA_W   = 16;
    parameter int PERM_W = 3;

    localparam int LEN_W  = OFF_W + 1;
    localparam int TLEN_W = SEG_W + 1;
    localparam int ENT_W  = PERM_W + LEN_W + PA_W;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_EXEC  = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_e;

    // Descriptor word: permissions on top, base at the bottom
    typedef struct packed {
        logic [PERM_W-1:0] perm;
        logic [LEN_W-1:0]  len;
        logic [PA_W-1:0]   base;
    } seg_ent_t;

    typedef struct packed {
        logic seg;
        logic bound;
        logic prot;
    } fault_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_CHECK = 2'd1,
        ST_WAIT  = 2'd2,
        ST_RESP  = 2'd3
    } xl_state_e;

    function automatic logic perm_ok(input logic [PERM_W-1:0] p, input acc_e a);
        case (a)
            ACC_READ:  return p[0];
            ACC_WRITE: return p[1];
            ACC_EXEC:  return p[2];
            default:   return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/seg_xlate_eval.sv
module seg_xlate_eval
    import seg_xlate_pkg::*;
(
    input  seg_ent_t         ent,
    input  logic [OFF_W-1:0] off,
    input  acc_e             acc,
    output logic             flt_bound,
    output logic             flt_prot,
    output logic [PA_W-1:0]  paddr
);

    logic over_len;
    logic denied;

    always_comb begin
        over_len  = ({1'b0, off} >= ent.len);
        denied    = !perm_ok(ent.perm, acc);
        // bounds outranks protection
        flt_bound = over_len;
        flt_prot  = denied && !over_len;
        paddr     = (over_len || denied) ? '0 : (ent.base + PA_W'(off));
    end

endmodule

// File: rtl/seg_xlate_tc.sv
module seg_xlate_tc
    import seg_xlate_pkg::*;
#(
    parameter int DEPTH = 4
)(
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic [SEG_W-1:0] lk_seg,
    output logic             hit,
    output seg_ent_t         hit_ent,
    input  logic             fill_en,
    input  logic [SEG_W-1:0] fill_seg,
    input  seg_ent_t         fill_ent
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [DEPTH-1:0] vld;
    logic [DEPTH-1:0] match;
    logic [SEG_W-1:0] tag  [DEPTH];
    seg_ent_t         slot [DEPTH];
    logic [PTR_W-1:0] ptr;

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        assign match[g] = vld[g] && (tag[g] == lk_seg);

        always_ff @(posedge clk) begin
            if (rst || flush) begin
                vld[g] <= 1'b0;
            end else if (fill_en && (ptr == PTR_W'(g))) begin
                vld[g]  <= 1'b1;
                tag[g]  <= fill_seg;
                slot[g] <= fill_ent;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            ptr <= '0;
        end else if (fill_en) begin
            ptr <= (ptr == PTR_W'(DEPTH - 1)) ? '0 : ptr + 1'b1;
        end
    end

    always_comb begin
        hit_ent = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (match[i]) hit_ent = hit_ent | slot[i];
        end
        hit = |match;
    end

endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
    import seg_xlate_pkg::*;
#(
    parameter int TC_DEPTH = 4
)(
    input  logic              clk,
    input  logic              rst,
    input  logic [MA_W-1:0]   tbl_origin,
    input  logic [TLEN_W-1:0] tbl_len,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [SEG_W-1:0]  req_seg,
    input  logic [OFF_W-1:0]  req_off,
    input  logic [1:0]        req_acc,
    output logic              mem_rd_en,
    output logic [MA_W-1:0]   mem_addr,
    input  logic              mem_rd_valid,
    input  logic [ENT_W-1:0]  mem_rd_data,
    output logic              rsp_valid,
    output logic [PA_W-1:0]   rsp_paddr,
    output logic              rsp_fault_seg,
    output logic              rsp_fault_bound,
    output logic              rsp_fault_prot
);

    xl_state_e         st;
    logic [SEG_W-1:0]  q_seg;
    logic [OFF_W-1:0]  q_off;
    acc_e              q_acc;
    logic [MA_W-1:0]   cfg_org_q;
    logic [TLEN_W-1:0] cfg_len_q;
    fault_t            rsp_flt;
    logic [PA_W-1:0]   rsp_pa;

    logic              seg_in_range;
    logic              cfg_change;
    logic              tc_hit;
    seg_ent_t          tc_ent;
    seg_ent_t          ev_ent;
    logic              ev_bound;
    logic              ev_prot;
    logic [PA_W-1:0]   ev_paddr;
    logic              fill_now;

    assign seg_in_range = ({1'b0, q_seg} < tbl_len);
    assign cfg_change   = (tbl_origin != cfg_org_q) || (tbl_len != cfg_len_q);
    assign fill_now     = (st == ST_WAIT) && mem_rd_valid;
    assign ev_ent       = (st == ST_WAIT) ? seg_ent_t'(mem_rd_data) : tc_ent;

    assign req_ready    = (st == ST_IDLE);
    assign mem_rd_en    = (st == ST_CHECK) && seg_in_range && !tc_hit;
    assign mem_addr     = tbl_origin + MA_W'(q_seg);

    assign rsp_valid       = (st == ST_RESP);
    assign rsp_paddr       = rsp_pa;
    assign rsp_fault_seg   = rsp_flt.seg;
    assign rsp_fault_bound = rsp_flt.bound;
    assign rsp_fault_prot  = rsp_flt.prot;

    seg_xlate_tc #(.DEPTH(TC_DEPTH)) u_tc (
        .clk      (clk),
        .rst      (rst),
        .flush    (cfg_change),
        .lk_seg   (q_seg),
        .hit      (tc_hit),
        .hit_ent  (tc_ent),
        .fill_en  (fill_now),
        .fill_seg (q_seg),
        .fill_ent (seg_ent_t'(mem_rd_data))
    );

    seg_xlate_eval u_eval (
        .ent       (ev_ent),
        .off       (q_off),
        .acc       (q_acc),
        .flt_bound (ev_bound),
        .flt_prot  (ev_prot),
        .paddr     (ev_paddr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_org_q <= tbl_origin;
            cfg_len_q <= tbl_len;
        end else begin
            cfg_org_q <= tbl_origin;
            cfg_len_q <= tbl_len;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_IDLE;
            q_seg   <= '0;
            q_off   <= '0;
            q_acc   <= ACC_READ;
            rsp_pa  <= '0;
            rsp_flt <= '0;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (req_valid) begin
                        q_seg <= req_seg;
                        q_off <= req_off;
                        q_acc <= acc_e'(req_acc);
                        st    <= ST_CHECK;
                    end
                end
                ST_CHECK: begin
                    if (!seg_in_range) begin
                        rsp_pa  <= '0;
                        rsp_flt <= '{seg: 1'b1, bound: 1'b0, prot: 1'b0};
                        st      <= ST_RESP;
                    end else if (tc_hit) begin
                        rsp_pa  <= ev_paddr;
                        rsp_flt <= '{seg: 1'b0, bound: ev_bound, prot: ev_prot};
                        st      <= ST_RESP;
                    end else begin
                        st <= ST_WAIT;
                    end
                end
                ST_WAIT: begin
                    if (mem_rd_valid) begin
                        rsp_pa  <= ev_paddr;
                        rsp_flt <= '{seg: 1'b0, bound: ev_bound, prot: ev_prot};
                        st      <= ST_RESP;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk
    import seg_xlate_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [MA_W-1:0]   tbl_origin,
    input logic [TLEN_W-1:0] tbl_len,
    input logic              req_valid,
    input logic              req_ready,
    input logic [SEG_W-1:0]  req_seg,
    input logic [OFF_W-1:0]  req_off,
    input logic              mem_rd_en,
    input logic [MA_W-1:0]   mem_addr,
    input logic              mem_rd_valid,
    input logic [ENT_W-1:0]  mem_rd_data,
    input logic              rsp_valid,
    input logic [PA_W-1:0]   rsp_paddr,
    input logic              rsp_fault_seg,
    input logic              rsp_fault_bound,
    input logic              rsp_fault_prot
);

    logic             rd_seen;
    logic [SEG_W-1:0] lat_seg;
    logic [OFF_W-1:0] lat_off;
    seg_ent_t         lat_ent;
    logic             any_flt;

    assign any_flt = rsp_fault_seg || rsp_fault_bound || rsp_fault_prot;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_seen <= 1'b0;
            lat_seg <= '0;
            lat_off <= '0;
            lat_ent <= '0;
        end else begin
            if (req_valid && req_ready) begin
                lat_seg <= req_seg;
                lat_off <= req_off;
                rd_seen <= 1'b0;
            end else if (mem_rd_en) begin
                rd_seen <= 1'b1;
            end
            if (mem_rd_valid) lat_ent <= seg_ent_t'(mem_rd_data);
        end
    end

    assert_sum_R1: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rd_seen && !any_flt) |-> (rsp_paddr == lat_ent.base + PA_W'(lat_off)));

    assert_segfault_R2: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (rsp_fault_seg == ({1'b0, lat_seg} >= tbl_len)));

    assert_no_read_on_segfault_R2: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_fault_seg) |-> !rd_seen);

    assert_bound_R3: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rd_seen) |-> (rsp_fault_bound == ({1'b0, lat_off} >= lat_ent.len)));

    assert_fault_onehot_R5: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $onehot0({rsp_fault_seg, rsp_fault_bound, rsp_fault_prot}));

    assert_fault_zero_addr_R5: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && any_flt) |-> (rsp_paddr == '0));

    assert_read_addr_R6: assert property (@(posedge clk) disable iff (rst)
        mem_rd_en |-> (mem_addr == tbl_origin + MA_W'(lat_seg)));

    assert_read_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        mem_rd_en |=> !mem_rd_en);

    assert_rsp_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);

    assert_busy_R9: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid || mem_rd_en) |-> !req_ready);

endmodule

bind seg_xlate seg_xlate_chk u_chk (
    .clk             (clk),
    .rst             (rst),
    .tbl_origin      (tbl_origin),
    .tbl_len         (tbl_len),
    .req_valid       (req_valid),
    .req_ready       (req_ready),
    .req_seg         (req_seg),
    .req_off         (req_off),
    .mem_rd_en       (mem_rd_en),
    .mem_addr        (mem_addr),
    .mem_rd_valid    (mem_rd_valid),
    .mem_rd_data     (mem_rd_data),
    .rsp_valid       (rsp_valid),
    .rsp_paddr       (rsp_paddr),
    .rsp_fault_seg   (rsp_fault_seg),
    .rsp_fault_bound (rsp_fault_bound),
    .rsp_fault_prot  (rsp_fault_prot)
);

// File: tb/sim_seg_xlate.sv
module sim_seg_xlate;
    import seg_xlate_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [MA_W-1:0]   tbl_origin = 16'h0100;
    logic [TLEN_W-1:0] tbl_len = 7'd20;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [SEG_W-1:0]  req_seg = '0;
    logic [OFF_W-1:0]  req_off = '0;
    logic [1:0]        req_acc = '0;
    logic              mem_rd_en;
    logic [MA_W-1:0]   mem_addr;
    logic              mem_rd_valid;
    logic [ENT_W-1:0]  mem_rd_data;
    logic              rsp_valid;
    logic [PA_W-1:0]   rsp_paddr;
    logic              rsp_fault_seg;
    logic              rsp_fault_bound;
    logic              rsp_fault_prot;

    always #2.5 clk = ~clk;

    seg_xlate #(.TC_DEPTH(4)) u0 (.*);

    typedef struct {
        logic [PA_W-1:0] pa;
        logic [2:0]      flt;
        string           tag;
    } exp_t;

    exp_t sb[$];
    int   n_chk   = 0;
    int   n_fail  = 0;
    int   rd_cnt  = 0;
    int   cur_org = 16'h0100;
    int   cur_tln = 20;
    bit   done    = 0;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Computed table contents: descriptor depends only on its memory address
    function automatic logic [ENT_W-1:0] gen(input int a);
        int b;
        int l;
        b = (a * 1237 + 40) % (1 << PA_W);
        l = ((a % 16) == 7) ? 0 : ((a * 29) % 3000 + 64);
        return {PERM_W'(a % 8), LEN_W'(l), PA_W'(b)};
    endfunction

    function automatic int lenof(input int seg);
        logic [ENT_W-1:0] e;
        e = gen(cur_org + seg);
        return int'(e[PA_W +: LEN_W]);
    endfunction

    function automatic exp_t model(input int seg, input int off, input int acc, input string tag);
        exp_t             r;
        logic [ENT_W-1:0] e;
        int               base;
        int               len;
        logic [2:0]       p;
        bit               ok;
        r.tag = tag;
        r.pa  = '0;
        r.flt = 3'b000;
        if (seg >= cur_tln) begin
            r.flt = 3'b100;
        end else begin
            e    = gen(cur_org + seg);
            base = int'(e[PA_W-1:0]);
            len  = int'(e[PA_W +: LEN_W]);
            p    = e[PA_W+LEN_W +: PERM_W];
            ok   = (acc == 0) ? p[0] : (acc == 1) ? p[1] : (acc == 2) ? p[2] : 1'b0;
            if (off >= len)  r.flt = 3'b010;
            else if (!ok)    r.flt = 3'b001;
            else             r.pa  = PA_W'(base + off);
        end
        return r;
    endfunction

    // Table memory: three cycles of read latency
    logic             v1, v2;
    logic [MA_W-1:0]  a1, a2;
    always @(posedge clk) begin
        if (rst) begin
            v1 <= 0; v2 <= 0; a1 <= '0; a2 <= '0;
            mem_rd_valid <= 0; mem_rd_data <= '0;
        end else begin
            v1 <= mem_rd_en; a1 <= mem_addr;
            v2 <= v1;        a2 <= a1;
            mem_rd_valid <= v2;
            mem_rd_data  <= gen(int'(a2));
        end
        if (!rst && mem_rd_en) rd_cnt <= rd_cnt + 1;
    end

    // Monitor / scoreboard
    always @(negedge clk) begin
        if (!rst && rsp_valid) begin
            if (sb.size() == 0) begin
                chk(0, "R9 unexpected response", 1, 0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                chk(rsp_paddr == e.pa, {e.tag, " paddr"}, rsp_paddr, e.pa);
                chk({rsp_fault_seg, rsp_fault_bound, rsp_fault_prot} == e.flt,
                    {e.tag, " faults(seg,bound,prot)"},
                    {rsp_fault_seg, rsp_fault_bound, rsp_fault_prot}, e.flt);
            end
        end
    end

    task automatic send(input int seg, input int off, input int acc, input int exp_reads, input string tag);
        int n0;
        sb.push_back(model(seg, off, acc, tag));
        n0 = rd_cnt;
        @(negedge clk);
        req_valid = 1'b1;
        req_seg   = SEG_W'(seg);
        req_off   = OFF_W'(off);
        req_acc   = 2'(acc);
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        chk(req_ready == 1'b0, "R9 ready low while busy", req_ready, 0);
        while (sb.size() != 0) @(negedge clk);
        @(negedge clk);
        chk(rd_cnt - n0 == exp_reads, {tag, " table reads"}, rd_cnt - n0, exp_reads);
    endtask

    task automatic set_cfg(input int org, input int tln);
        @(negedge clk);
        tbl_origin = MA_W'(org);
        tbl_len    = TLEN_W'(tln);
        cur_org    = org;
        cur_tln    = tln;
        @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            chk(0, "R9 watchdog expired", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(req_ready == 1'b1, "R10 ready after reset", req_ready, 1);
        chk(rsp_valid == 1'b0, "R10 no response after reset", rsp_valid, 0);
        chk(mem_rd_en == 1'b0, "R10 no read after reset", mem_rd_en, 0);

        // R1 R6: first use of segment 3 misses; R7: second use hits
        send(3, 5, 0, 1, "R1 R6 miss translate");
        send(3, lenof(3) - 1, 0, 0, "R7 hit, R3 last legal offset");
        send(3, lenof(3), 0, 0, "R3 offset equal to length");
        send(3, 0, 2, 0, "R4 exec not permitted");
        send(3, 0, 3, 0, "R4 reserved code");
        send(3, 9, 1, 0, "R4 write permitted");
        send(7, 0, 0, 1, "R3 zero-length segment");
        send(2, lenof(2), 0, 1, "R5 bounds outranks protection");
        send(2, 0, 0, 0, "R4 read denied");
        send(20, 0, 0, 0, "R2 segment equal to table length");
        send(63, 4095, 3, 0, "R5 segment fault outranks all");
        send(19, 1, 0, 1, "R2 last valid segment");

        // R8: new origin flushes cache
        set_cfg(16'h0200, 20);
        send(3, 0, 0, 1, "R8 origin change refetches");
        // R7: round-robin replacement over 4 slots
        send(1, 0, 0, 1, "R7 fill slot1");
        send(5, 0, 0, 1, "R7 fill slot2");
        send(9, 0, 0, 1, "R7 fill slot3");
        send(11, 0, 0, 1, "R7 evict slot0");
        send(1, 0, 0, 0, "R7 survivor hits");
        send(3, 0, 0, 1, "R7 evicted entry refetched");

        // R8: table length change flushes too
        set_cfg(16'h0200, 30);
        send(5, 2, 0, 1, "R8 length change refetches");
        send(25, 0, 0, 1, "R2 segment now in range");

        done = 1;
        repeat (4) @(negedge clk);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule